// File: doc/BRIEF.md
# Self-Timed Byte-Write Sequencer for a Parallel Nonvolatile Memory

This block is a clock-synchronous model of the control logic in a byte-wide parallel nonvolatile memory. The host uses it like a static RAM. It drives three active-low strobes: chip select, output enable and write enable. It also drives an address and a data byte, and all of these are sampled on the system clock.

A write strobe latches one address and one data byte. An internal timer then runs a clear phase, in which the target byte is forced to all ones, followed by a program phase. While the timer runs, an open-drain style busy output pulls low. Any read during that time returns polling data, with the top bit inverted from the byte being written.

Writes are blocked in three cases: while the supply-good input is low, during a power-on lockout window after that input rises or after reset, and by illegal strobe combinations. A high-voltage flag on the output-enable pin selects a timed whole-array erase. A high-voltage flag on an address pin maps the top 32 addresses onto a separate identification memory.

Top module: `eeprom_write_seq`

## Requirements
- R1: With cs_n and rd_n low and wr_n high, data_oe is 1 and data_out carries the stored byte at addr. With cs_n or rd_n high, data_oe is 0.
- R2: A write strobe is the state where cs_n and wr_n are both low while rd_n is high and hv_rd is 0. The address is taken in the first cycle of the strobe. The data is taken in the last cycle of the strobe. The write starts in the cycle after the strobe ends.
- R3: busy_pull is 1 from the clock edge that starts a write for exactly TWC cycles, where TWC is TWC_FAST_CYC when FAST_WRITE is 1 and TWC_SLOW_CYC otherwise. The first CLR_CYC of those cycles form the clear phase.
- R4: Once busy_pull returns to 0, a read of the written address returns the new byte. Every other address keeps its contents.
- R5: Any read while busy_pull is 1 returns the inverse of the pending byte's bit 7 on data_out[7], and 0 on bits 6 to 0.
- R6: A strobe with rd_n low, or with only one of cs_n and wr_n low, writes nothing and does not raise busy_pull.
- R7: While vcc_ok is 0, neither a byte write nor an array erase takes place.
- R8: Writes and erases stay blocked for POR_CYC cycles after reset is released or after vcc_ok rises.
- R9: With hv_rd at 1, holding cs_n and wr_n low for ERASE_CYC cycles sets every main-array byte to 0xFF. A shorter hold changes nothing.
- R10: With hv_a9 at 1, addresses whose upper bits above the low 5 are all ones read and write a separate 32-byte memory, indexed by addr[4:0]. The main array at the same addresses is left untouched. With hv_a9 at 0, those addresses reach the main array.
- R11: Strobes that arrive while busy_pull is 1 are ignored and are not queued for later.
- R12: A synchronous reset drops busy_pull in the next cycle and restarts the lockout of R8. Stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Host write data |
| data_out | output | DATA_W | Read data or polling data |
| data_oe | output | 1 | 1 when the block drives the data bus |
| busy_pull | output | 1 | 1 pulls the shared ready line low |
| vcc_ok | input | 1 | Supply-good indication |
| hv_rd | input | 1 | High voltage present on output enable (erase mode) |
| hv_a9 | input | 1 | High voltage present on the address pin (identification area) |

## Verification
Assertions check on every cycle that a write starts only when the timer is idle and the supply is good, and that busy follows every start. They also check that the block stays locked and not busy in the cycle after reset, and that an erase never coincides with a timed byte write. Only the bench scenarios can show the data-side effects. These are the exact busy length, the polling value, the data captured from a multi-cycle strobe, the erase result against its hold time, the separation of the identification area, and the fact that ignored strobes leave stored bytes unchanged.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CLEAR = 2'd1,
      PH_PROG  = 2'd2
   } wr_phase_e;
endpackage

// File: rtl/eeprom_por_lock.sv
module eeprom_por_lock #(
   parameter int POR_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic vcc_ok,
   output logic write_ok
);
   localparam int LW = $clog2(POR_CYC + 1);

   logic [LW-1:0] lock_cnt;

   initial begin
      assert (POR_CYC >= 1) else $error("POR_CYC must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || !vcc_ok) begin
         lock_cnt <= LW'(POR_CYC);
      end else if (lock_cnt != '0) begin
         lock_cnt <= lock_cnt - 1'b1;
      end
   end

   assign write_ok = vcc_ok && (lock_cnt == '0);
endmodule

// File: rtl/eeprom_strobe_ctl.sv
module eeprom_strobe_ctl #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int ERASE_CYC = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              hv_rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              id_sel,
   input  logic [DATA_W-1:0] data_in,
   input  logic              busy,
   input  logic              write_ok,
   output logic              start,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              cap_id,
   output logic [DATA_W-1:0] cap_data,
   output logic              erase_all
);
   localparam int EW = $clog2(ERASE_CYC + 1);

   logic          wl, wl_q, armed;
   logic          el, e_done;
   logic [EW-1:0] e_cnt;

   initial begin
      assert (ERASE_CYC >= 2) else $error("ERASE_CYC must be at least 2");
   end

   // combined write strobe: both selects low, output disabled, normal voltage
   assign wl = !cs_n && !wr_n && rd_n && !hv_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         wl_q  <= 1'b0;
         armed <= 1'b0;
      end else begin
         wl_q <= wl;
         if (wl && !wl_q && !busy) begin
            armed <= 1'b1;
         end else if (!wl) begin
            armed <= 1'b0;
         end
      end
   end

   // address at strobe entry, data tracked until strobe exit
   always_ff @(posedge clk) begin
      if (wl && !wl_q && !busy) begin
         cap_addr <= addr;
         cap_id   <= id_sel;
      end
      if (wl && !busy) begin
         cap_data <= data_in;
      end
   end

   assign start = armed && wl_q && !wl && rd_n && write_ok && !busy;

   // timed whole-array erase
   assign el = !cs_n && !wr_n && hv_rd;

   always_ff @(posedge clk) begin
      if (rst || !el) begin
         e_cnt  <= '0;
         e_done <= 1'b0;
      end else if (!e_done && write_ok && !busy) begin
         if (e_cnt == EW'(ERASE_CYC - 1)) begin
            e_done <= 1'b1;
         end else begin
            e_cnt <= e_cnt + 1'b1;
         end
      end
   end

   assign erase_all = el && !e_done && write_ok && !busy &&
                      (e_cnt == EW'(ERASE_CYC - 1));
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer
   import eeprom_seq_pkg::*;
#(
   parameter int CLR_CYC      = 4,
   parameter int TWC_FAST_CYC = 16,
   parameter int TWC_SLOW_CYC = 64,
   parameter bit FAST_WRITE   = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy,
   output logic wr_en,
   output logic wr_fill
);
   localparam int TWC = FAST_WRITE ? TWC_FAST_CYC : TWC_SLOW_CYC;
   localparam int CW  = $clog2(TWC + 1);

   wr_phase_e     ph;
   logic [CW-1:0] cnt;

   initial begin
      assert (CLR_CYC >= 1 && CLR_CYC < TWC)
         else $error("CLR_CYC must lie in 1..TWC-1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph  <= PH_CLEAR;
                  cnt <= CW'(CLR_CYC - 1);
               end
            end
            PH_CLEAR: begin
               if (cnt == '0) begin
                  ph  <= PH_PROG;
                  cnt <= CW'(TWC - CLR_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_PROG: begin
               if (cnt == '0) begin
                  ph <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (ph != PH_IDLE);
   assign wr_en   = busy && (cnt == '0);
   assign wr_fill = (ph == PH_CLEAR);

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
      start |=> busy); // R3
   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy); // R11
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 8,
   parameter int ID_BYTES = 32,
   parameter bit ID_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_id,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_id,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              erase_all
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int ID_AW = $clog2(ID_BYTES);

   logic [DATA_W-1:0] main_mem [DEPTH];
   logic [DATA_W-1:0] main_rd;
   logic [DATA_W-1:0] id_rd;

   always_ff @(posedge clk) begin
      if (erase_all) begin
         for (int i = 0; i < DEPTH; i++) begin
            main_mem[i] <= '1;
         end
      end else if (wr_en && !wr_id) begin
         main_mem[wr_addr] <= wr_data;
      end
   end

   assign main_rd = main_mem[rd_addr];

   generate
      if (ID_EN) begin : g_id
         logic [DATA_W-1:0] id_mem [ID_BYTES];
         always_ff @(posedge clk) begin
            if (wr_en && wr_id) begin
               id_mem[wr_addr[ID_AW-1:0]] <= wr_data;
            end
         end
         assign id_rd = id_mem[rd_addr[ID_AW-1:0]];
      end else begin : g_no_id
         assign id_rd = main_rd;
      end
   endgenerate

   assign rd_data = rd_id ? id_rd : main_rd;

   AST_ERASE_NOT_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
      erase_all |-> !wr_en); // R9
endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq #(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 8,
   parameter int ID_BYTES     = 32,
   parameter bit ID_EN        = 1'b1,
   parameter bit FAST_WRITE   = 1'b0,
   parameter int CLR_CYC      = 1000,
   parameter int TWC_FAST_CYC = 10000,
   parameter int TWC_SLOW_CYC = 50000,
   parameter int POR_CYC      = 250000,
   parameter int ERASE_CYC    = 500000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              busy_pull,
   input  logic              vcc_ok,
   input  logic              hv_rd,
   input  logic              hv_a9
);
   localparam int ID_AW = $clog2(ID_BYTES);

   logic              id_sel, write_ok, start, busy, wr_en, wr_fill, erase_all;
   logic              cap_id;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data, rd_data, wr_data;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (ID_BYTES == (1 << ID_AW)) else $error("ID_BYTES must be a power of two");
      assert (ADDR_W > ID_AW) else $error("ADDR_W must exceed the ID window width");
   end

   generate
      if (ID_EN) begin : g_win
         assign id_sel = hv_a9 && (&addr[ADDR_W-1:ID_AW]);
      end else begin : g_no_win
         assign id_sel = 1'b0;
      end
   endgenerate

   eeprom_por_lock #(.POR_CYC(POR_CYC)) u_lock (
      .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .write_ok(write_ok)
   );

   eeprom_strobe_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC)) u_strb (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hv_rd(hv_rd),
      .addr(addr), .id_sel(id_sel), .data_in(data_in), .busy(busy),
      .write_ok(write_ok), .start(start), .cap_addr(cap_addr), .cap_id(cap_id),
      .cap_data(cap_data), .erase_all(erase_all)
   );

   eeprom_wr_timer #(
      .CLR_CYC(CLR_CYC), .TWC_FAST_CYC(TWC_FAST_CYC),
      .TWC_SLOW_CYC(TWC_SLOW_CYC), .FAST_WRITE(FAST_WRITE)
   ) u_tmr (
      .clk(clk), .rst(rst), .start(start), .busy(busy), .wr_en(wr_en), .wr_fill(wr_fill)
   );

   assign wr_data = wr_fill ? '1 : cap_data;

   eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BYTES(ID_BYTES), .ID_EN(ID_EN)) u_mem (
      .clk(clk), .rst(rst), .rd_addr(addr), .rd_id(id_sel), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(cap_addr), .wr_id(cap_id), .wr_data(wr_data),
      .erase_all(erase_all)
   );

   assign data_oe   = !cs_n && !rd_n && wr_n;
   assign data_out  = busy ? {~cap_data[DATA_W-1], {(DATA_W-1){1'b0}}} : rd_data;
   assign busy_pull = busy;

   AST_START_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
      start |-> vcc_ok); // R7
   AST_LOCKED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !write_ok); // R8
   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !busy_pull); // R12
endmodule

// File: tb/tb_eeprom_write_seq.sv
`timescale 1ns/1ps
module tb_eeprom_write_seq;
   localparam int AW  = 6;
   localparam int DW  = 8;
   localparam int NB  = 1 << AW;
   localparam int IDB = 32;
   localparam int CLR = 3;
   localparam int TWC = 8;
   localparam int POR = 10;
   localparam int ERC = 12;

   logic clk = 1'b0, rst = 1'b1;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data_in = '0;
   logic [DW-1:0] data_out;
   logic data_oe, busy_pull;
   logic vcc_ok = 1'b1, hv_rd = 1'b0, hv_a9 = 1'b0;

   int total = 0, bad = 0;
   logic [DW-1:0] exp_main [NB];
   logic [DW-1:0] exp_id   [IDB];

   always #2.5 clk = ~clk;

   eeprom_write_seq #(
      .ADDR_W(AW), .DATA_W(DW), .ID_BYTES(IDB), .ID_EN(1'b1), .FAST_WRITE(1'b1),
      .CLR_CYC(CLR), .TWC_FAST_CYC(TWC), .TWC_SLOW_CYC(20), .POR_CYC(POR), .ERASE_CYC(ERC)
   ) dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .busy_pull(busy_pull),
      .vcc_ok(vcc_ok), .hv_rd(hv_rd), .hv_a9(hv_a9)
   );

   function automatic logic [DW-1:0] pat(int a);
      return DW'(a * 29 + 90);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(int a, output logic [DW-1:0] d, output logic oe);
      @(negedge clk);
      addr = AW'(a); cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
      #1;
      d = data_out; oe = data_oe;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic pulse(int a, logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); data_in = d; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   // full write with busy-length and polling checks
   task automatic wr_full(int a, logic [DW-1:0] d, string tag);
      int n = 0;
      pulse(a, d);
      @(negedge clk);
      addr = AW'(a); cs_n = 1'b0; rd_n = 1'b0;
      #1;
      chk("R5 poll", {data_oe, data_out}, {1'b1, ~d[DW-1], {(DW-1){1'b0}}});
      cs_n = 1'b1; rd_n = 1'b1;
      while (busy_pull && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk({"R3 busy length ", tag}, n, TWC);
   endtask

   task automatic chk_main(string req);
      logic [DW-1:0] d;
      logic oe;
      for (int a = 0; a < NB; a++) begin
         rd(a, d, oe);
         chk(req, {oe, d}, {1'b1, exp_main[a]});
      end
   endtask

   task automatic erase_hold(int cyc);
      @(negedge clk);
      hv_rd = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
      repeat (cyc) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; hv_rd = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] d;
      logic oe;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R12 busy clear after reset", busy_pull, 0);
      chk("R1 bus released when deselected", data_oe, 0);

      // write attempt inside the power-on lockout
      pulse(5, 8'h11);
      @(negedge clk);
      chk("R8 lockout blocks write", busy_pull, 0);
      repeat (POR + 5) @(negedge clk);

      // long erase fills array with ones
      erase_hold(ERC + 2);
      for (int a = 0; a < NB; a++) exp_main[a] = 8'hFF;
      chk_main("R9 erase sets 0xFF");

      // sweep all addresses
      for (int a = 0; a < NB; a++) begin
         wr_full(a, pat(a), "sweep");
         exp_main[a] = pat(a);
         rd(a, d, oe);
         chk("R4 readback", {oe, d}, {1'b1, pat(a)});
      end
      chk_main("R4 whole array after sweep");

      // two-cycle strobe: address from first cycle, data from last
      @(negedge clk);
      addr = 6'd12; data_in = 8'h01; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      addr = 6'd13; data_in = 8'hA5;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (TWC + 2) @(negedge clk);
      exp_main[12] = 8'hA5;
      rd(12, d, oe);
      chk("R2 address first data last", d, 8'hA5);
      rd(13, d, oe);
      chk("R2 neighbour untouched", d, exp_main[13]);

      // short erase has no effect
      erase_hold(3);
      chk_main("R9 short erase ignored");

      // identification area
      hv_a9 = 1'b1;
      for (int a = NB - IDB; a < NB; a++) begin
         wr_full(a, ~pat(a), "id");
         exp_id[a - (NB - IDB)] = ~pat(a);
      end
      for (int a = NB - IDB; a < NB; a++) begin
         rd(a, d, oe);
         chk("R10 id area readback", d, exp_id[a - (NB - IDB)]);
      end
      rd(3, d, oe);
      chk("R10 low addresses still main", d, exp_main[3]);
      hv_a9 = 1'b0;
      for (int a = NB - IDB; a < NB; a++) begin
         rd(a, d, oe);
         chk("R10 main array under id window", d, exp_main[a]);
      end

      // rd_n low during strobe
      @(negedge clk);
      addr = 6'd3; data_in = 8'h00; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      chk("R6 rd_n low inhibits", busy_pull, 0);
      // only wr_n low
      @(negedge clk);
      addr = 6'd3; cs_n = 1'b1; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      chk("R6 cs_n high inhibits", busy_pull, 0);
      rd(3, d, oe);
      chk("R6 byte unchanged", d, exp_main[3]);

      // supply low
      vcc_ok = 1'b0;
      pulse(4, 8'h00);
      @(negedge clk);
      chk("R7 supply low blocks write", busy_pull, 0);
      erase_hold(ERC + 2);
      chk_main("R7 supply low blocks erase");
      vcc_ok = 1'b1;
      pulse(4, 8'h00);
      @(negedge clk);
      chk("R8 lockout after supply rise", busy_pull, 0);
      repeat (POR + 5) @(negedge clk);
      rd(4, d, oe);
      chk("R7 byte kept", d, exp_main[4]);

      // strobe while busy is dropped
      pulse(7, 8'hC3);
      pulse(8, 8'h3C);
      repeat (TWC + 2) @(negedge clk);
      chk("R11 nothing queued", busy_pull, 0);
      exp_main[7] = 8'hC3;
      rd(7, d, oe);
      chk("R11 first write done", d, 8'hC3);
      rd(8, d, oe);
      chk("R11 busy strobe ignored", d, exp_main[8]);

      // reset mid-write
      pulse(9, 8'h77);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R12 reset drops busy", busy_pull, 0);
      rd(10, d, oe);
      chk("R12 contents kept", d, exp_main[10]);
      pulse(10, 8'h00);
      @(negedge clk);
      chk("R12 lockout restarted", busy_pull, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule